// File: doc/BRIEF.md
# Burst-Mode Controller State Engine

This block is a clocked stand-in for an asynchronous burst-mode Mealy controller. A parameter table lists its edges. Each edge names a source state and a destination state. Each edge also names the input transitions it needs (rising or falling), the optional transitions it tolerates, and any input levels that must hold when it fires. Finally, each edge names the outputs it toggles. The handshake inputs arrive asynchronously and pass through a two-flop synchroniser. The engine compares them with a snapshot taken when the current stable state was entered. From that comparison it knows which transitions have happened since entry.

An edge fires once its whole multiple-input-change burst has happened, in any order. When it fires, the state move and the output toggles take effect on the same clock edge, and the snapshot is refreshed. Any transition that no edge leaving the current state allows is flagged as an error and freezes the engine. So is a signal that reverses direction within a pending burst. An optional transition can be marked to stay pending into the destination state, where a later edge must require it.

The default table models a burst-mode flip-flop. Input bit 0 is the data line, bit 1 is the clock-like line, and bit 2 is a spare that no edge lists. Output bit 0 is the stored value.

Top module: `bm_engine`

## Requirements
- R1: After a synchronous active-low reset the engine is in state 0, all outputs are 0 and the error flag is 0 (the default initial values).
- R2: With the default table, a rising transition on input bit 1 while input bit 0 is 1 moves the engine from state 0 to state 1 and raises output bit 0. The same rising transition with bit 0 at 0 moves it from state 1 to state 0 and lowers output bit 0.
- R3: Outputs and state change only on a clock edge where `fire_o` is set. The output toggles and the state move appear together, three clock edges after the completing input change reaches `in_async`, and each firing pulses `fire_o` for exactly one cycle.
- R4: Held input levels choose between edges that share the same required transitions. With the default table, a rising bit 1 while bit 0 is 0 in state 0 fires a self-loop that leaves state and outputs unchanged. A falling bit 1 always fires a self-loop.
- R5: A transition that the current state's edges list as optional raises no error and does not fire any edge by itself.
- R6: A transition that no edge leaving the current state lists, such as any change on default input bit 2, sets `err_o`. After that, no edge fires and outputs and state hold.
- R7: A signal that returns to its snapshot value after it has changed within the pending burst sets `err_o`. This applies to a carried pending transition as well.
- R8: With no input change, no edge fires, however many cycles pass.
- R9: An optional transition marked as carried stays pending into the destination state and there counts toward a later edge's required set. That later edge still waits for at least one required transition that happens after entry.
- R10: After a firing, the engine accepts no further firing on the next cycle.
- R11: `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_async | input | N_IN | Asynchronous handshake inputs |
| out_o | output | N_OUT | Registered controller outputs |
| state_o | output | SW | Current stable state number |
| fire_o | output | 1 | One-cycle pulse when an edge has fired |
| err_o | output | 1 | Sticky illegal-input-activity flag |

## Verification
The bench builds two instances. The first uses the default six-edge flip-flop table with three inputs. Its data pattern is swept across repeated clock-like cycles, which covers both level-selected edges from both states, the falling self-loops, the unlisted spare input and data reversals. The second instance has two inputs, one output and two edges, and one optional transition is marked as carried. It brings the long pending transition within reach: the transition may arrive early, arrive late, or reverse after being carried.

// File: rtl/bm_pkg.sv
// Package: constants shared by the burst-mode engine modules.
// Assumes: nothing beyond IEEE 1800-2017.
package bm_pkg;
    // Depth of the input synchroniser chain.
    localparam int unsigned BM_SYNC_STAGES = 2;

    // Classification of an input bit relative to the state-entry snapshot.
    typedef enum logic [1:0] {
        BM_STEADY  = 2'b00,
        BM_ROSE    = 2'b01,
        BM_FELL    = 2'b10
    } bm_move_e;
endpackage

// File: rtl/bm_sync.sv
// Module: bm_sync
// Multi-stage synchroniser for a vector of asynchronous handshake inputs.
// Assumes: each input is held long enough to be sampled (fundamental mode);
// the reset value equals the expected idle input levels.
module bm_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= INIT;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bm_tracker.sv
// Module: bm_tracker
// Keeps the state-entry input snapshot, the mask of bits seen changing since
// entry and the mask of transitions carried in from the previous edge.
// Derives the rise/fall vectors and detects a reversal inside a burst.
// Assumes: fire is only asserted when the burst on the current state is legal.
module bm_tracker #(
    parameter int unsigned N_IN      = 3,
    parameter logic [N_IN-1:0] INIT_IN = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] s,
    input  logic            fire,
    input  logic [N_IN-1:0] carry_mask,
    output logic [N_IN-1:0] chg,
    output logic [N_IN-1:0] rise,
    output logic [N_IN-1:0] fall,
    output logic [N_IN-1:0] pre,
    output logic            reversal
);
    import bm_pkg::*;

    logic [N_IN-1:0] snap_q;
    logic [N_IN-1:0] seen_q;
    logic [N_IN-1:0] pre_q;
    logic [N_IN-1:0] keep;
    bm_move_e        move [N_IN];

    // Per-bit movement classification against the snapshot.
    always_comb begin
        for (int b = 0; b < N_IN; b++) begin
            if (s[b] == snap_q[b])  move[b] = BM_STEADY;
            else if (s[b])          move[b] = BM_ROSE;
            else                    move[b] = BM_FELL;
        end
    end

    // Collapse the classification into vectors for the edge matcher.
    always_comb begin
        for (int b = 0; b < N_IN; b++) begin
            rise[b] = (move[b] == BM_ROSE);
            fall[b] = (move[b] == BM_FELL);
        end
        chg      = rise | fall;
        keep     = carry_mask & chg;
        reversal = |(seen_q & ~chg);
        pre      = pre_q;
    end

    // Refresh the snapshot on a firing, keeping carried transitions pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= INIT_IN;
            seen_q <= '0;
            pre_q  <= '0;
        end else if (fire) begin
            snap_q <= (s & ~keep) | (snap_q & keep);
            seen_q <= keep;
            pre_q  <= keep;
        end else begin
            seen_q <= seen_q | chg;
        end
    end

    // R9: a carried bit is still seen as changed right after the firing.
    a_r9_carry_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && |keep) |=> ((pre_q & seen_q) == pre_q));
endmodule

// File: rtl/bm_match.sv
// Module: bm_match
// Evaluates every edge of the parameter table against the current state and
// the observed burst; returns the legal transition masks for the state and
// the lowest-index eligible edge.
// Assumes: table vectors are packed with edge e at slice [e*W +: W].
module bm_match #(
    parameter int unsigned N_IN   = 3,
    parameter int unsigned N_OUT  = 1,
    parameter int unsigned SW     = 1,
    parameter int unsigned N_EDGE = 6,
    parameter logic [N_EDGE*SW-1:0]    EDGE_SRC   = '0,
    parameter logic [N_EDGE*SW-1:0]    EDGE_DST   = '0,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_RISE  = '0,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_FALL  = '0,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_OPT   = '0,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_CARRY = '0,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_LVLM  = '0,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_LVLV  = '0,
    parameter logic [N_EDGE*N_OUT-1:0] EDGE_TOG   = '0
) (
    input  logic [SW-1:0]    cur_state,
    input  logic [N_IN-1:0]  s,
    input  logic [N_IN-1:0]  chg,
    input  logic [N_IN-1:0]  rise,
    input  logic [N_IN-1:0]  fall,
    input  logic [N_IN-1:0]  pre,
    output logic [N_IN-1:0]  legal_rise,
    output logic [N_IN-1:0]  legal_fall,
    output logic             hit,
    output logic [SW-1:0]    hit_dst,
    output logic [N_OUT-1:0] hit_tog,
    output logic [N_IN-1:0]  hit_carry
);
    logic [N_EDGE-1:0] elig;
    logic [N_IN-1:0]   lr_arr [N_EDGE];
    logic [N_IN-1:0]   lf_arr [N_EDGE];

    for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
        localparam logic [SW-1:0]   SRC  = EDGE_SRC[e*SW +: SW];
        localparam logic [N_IN-1:0] RQR  = EDGE_RISE[e*N_IN +: N_IN];
        localparam logic [N_IN-1:0] RQF  = EDGE_FALL[e*N_IN +: N_IN];
        localparam logic [N_IN-1:0] OPT  = EDGE_OPT[e*N_IN +: N_IN] | EDGE_CARRY[e*N_IN +: N_IN];
        localparam logic [N_IN-1:0] LVM  = EDGE_LVLM[e*N_IN +: N_IN];
        localparam logic [N_IN-1:0] LVV  = EDGE_LVLV[e*N_IN +: N_IN];
        logic src_ok;

        // Edge applies only while the engine sits in its source state.
        assign src_ok     = (cur_state == SRC);
        assign lr_arr[e]  = src_ok ? (RQR | OPT) : '0;
        assign lf_arr[e]  = src_ok ? (RQF | OPT) : '0;
        // Burst complete, held levels match, and one required bit is fresh.
        assign elig[e] = src_ok
                      && ((RQR & ~rise) == '0)
                      && ((RQF & ~fall) == '0)
                      && (((s ^ LVV) & LVM) == '0)
                      && (((RQR | RQF) & chg & ~pre) != '0);
    end

    // Union of the transitions any edge of the current state tolerates.
    always_comb begin
        legal_rise = '0;
        legal_fall = '0;
        for (int e = 0; e < N_EDGE; e++) begin
            legal_rise = legal_rise | lr_arr[e];
            legal_fall = legal_fall | lf_arr[e];
        end
    end

    // Lowest-index eligible edge wins.
    always_comb begin
        hit       = 1'b0;
        hit_dst   = '0;
        hit_tog   = '0;
        hit_carry = '0;
        for (int e = N_EDGE - 1; e >= 0; e--) begin
            if (elig[e]) begin
                hit       = 1'b1;
                hit_dst   = EDGE_DST[e*SW +: SW];
                hit_tog   = EDGE_TOG[e*N_OUT +: N_OUT];
                hit_carry = EDGE_CARRY[e*N_IN +: N_IN];
            end
        end
    end
endmodule

// File: rtl/bm_engine.sv
// Module: bm_engine (top)
// Clocked burst-mode Mealy controller. Synchronises the handshake inputs,
// tracks transitions since the last stable state, fires the matching table
// edge (state move and output toggles together) and flags illegal activity.
// Assumes: the environment obeys fundamental mode; the default table is a
// flip-flop: in[0]=data, in[1]=clock-like, in[2]=unused spare, out[0]=value.
module bm_engine #(
    parameter int unsigned N_IN    = 3,
    parameter int unsigned N_OUT   = 1,
    parameter int unsigned N_STATE = 2,
    parameter int unsigned N_EDGE  = 6,
    parameter int unsigned SW      = (N_STATE > 1) ? $clog2(N_STATE) : 1,
    parameter logic [N_IN-1:0]  INIT_IN    = '0,
    parameter logic [N_OUT-1:0] INIT_OUT   = '0,
    parameter logic [SW-1:0]    INIT_STATE = '0,
    parameter logic [N_EDGE*SW-1:0]    EDGE_SRC   = 6'b111000,
    parameter logic [N_EDGE*SW-1:0]    EDGE_DST   = 6'b101001,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_RISE  = 18'b000_010_010_000_010_010,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_FALL  = 18'b010_000_000_010_000_000,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_OPT   = 18'b001_001_001_001_001_001,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_CARRY = 18'b000_000_000_000_000_000,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_LVLM  = 18'b000_001_001_000_001_001,
    parameter logic [N_EDGE*N_IN-1:0]  EDGE_LVLV  = 18'b000_000_001_000_000_001,
    parameter logic [N_EDGE*N_OUT-1:0] EDGE_TOG   = 6'b010001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_async,
    output logic [N_OUT-1:0] out_o,
    output logic [SW-1:0]    state_o,
    output logic             fire_o,
    output logic             err_o
);
    import bm_pkg::*;

    logic [N_IN-1:0]  s;
    logic [N_IN-1:0]  chg, rise, fall, pre;
    logic             reversal;
    logic [N_IN-1:0]  legal_rise, legal_fall;
    logic             hit;
    logic [SW-1:0]    hit_dst;
    logic [N_OUT-1:0] hit_tog;
    logic [N_IN-1:0]  hit_carry;
    logic             illegal;
    logic             fire;
    logic [SW-1:0]    state_q;
    logic [N_OUT-1:0] out_q;
    logic             err_q;
    logic             fire_q;

    bm_sync #(.W(N_IN), .STAGES(BM_SYNC_STAGES), .INIT(INIT_IN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(in_async), .q(s)
    );

    bm_tracker #(.N_IN(N_IN), .INIT_IN(INIT_IN)) u_track (
        .clk(clk), .rst_n(rst_n), .s(s), .fire(fire), .carry_mask(hit_carry),
        .chg(chg), .rise(rise), .fall(fall), .pre(pre), .reversal(reversal)
    );

    bm_match #(
        .N_IN(N_IN), .N_OUT(N_OUT), .SW(SW), .N_EDGE(N_EDGE),
        .EDGE_SRC(EDGE_SRC), .EDGE_DST(EDGE_DST), .EDGE_RISE(EDGE_RISE),
        .EDGE_FALL(EDGE_FALL), .EDGE_OPT(EDGE_OPT), .EDGE_CARRY(EDGE_CARRY),
        .EDGE_LVLM(EDGE_LVLM), .EDGE_LVLV(EDGE_LVLV), .EDGE_TOG(EDGE_TOG)
    ) u_match (
        .cur_state(state_q), .s(s), .chg(chg), .rise(rise), .fall(fall),
        .pre(pre), .legal_rise(legal_rise), .legal_fall(legal_fall),
        .hit(hit), .hit_dst(hit_dst), .hit_tog(hit_tog), .hit_carry(hit_carry)
    );

    // Unlisted direction or a reversal inside the burst is illegal.
    assign illegal = (|(rise & ~legal_rise)) || (|(fall & ~legal_fall)) || reversal;
    // Fire only when legal, not frozen, and not in the settle cycle.
    assign fire    = hit && !illegal && !err_q && !fire_q;

    // Commit the state move, output toggles and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT_STATE;
            out_q   <= INIT_OUT;
            err_q   <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= fire;
            if (fire) begin
                state_q <= hit_dst;
                out_q   <= out_q ^ hit_tog;
            end
            if (illegal && !fire_q) err_q <= 1'b1;
        end
    end

    assign out_o   = out_q;
    assign state_o = state_q;
    assign fire_o  = fire_q;
    assign err_o   = err_q;

    // R1: first cycle after reset shows the initial values.
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q == INIT_STATE && out_q == INIT_OUT && !err_q));
    // R3: outputs move only together with a firing.
    a_r3_out_with_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> fire_q);
    // R3: state moves only together with a firing.
    a_r3_state_with_fire: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> fire_q);
    // R6: a frozen engine never fires.
    a_r6_err_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !fire_q);
    // R10: no firing in the cycle after a firing.
    a_r10_settle: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
    // R11: the error flag is sticky.
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: tb/bm_engine_tb.sv
`timescale 1ns/1ps
module bm_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] din = 3'b000;
    logic [1:0] ain = 2'b00;
    logic [0:0] q_o, ao_o;
    logic [0:0] st_o, ast_o;
    logic       fire_o, afire_o, err_o, aerr_o;
    int checks = 0, failures = 0;
    int dfires = 0, afires = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bm_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_async(din), .out_o(q_o),
        .state_o(st_o), .fire_o(fire_o), .err_o(err_o)
    );

    // Long-arc table: in[0]=x, in[1]=y. E0: 0->1 on x rise, y optional and
    // carried, toggle out. E1: 1->0 on x fall plus y rise, toggle out.
    bm_engine #(
        .N_IN(2), .N_OUT(1), .N_STATE(2), .N_EDGE(2),
        .EDGE_SRC(2'b10), .EDGE_DST(2'b01),
        .EDGE_RISE(4'b1001), .EDGE_FALL(4'b0100),
        .EDGE_OPT(4'b0010), .EDGE_CARRY(4'b0010),
        .EDGE_LVLM(4'b0000), .EDGE_LVLV(4'b0000), .EDGE_TOG(2'b11)
    ) u_arc (
        .clk(clk), .rst_n(rst_n), .in_async(ain), .out_o(ao_o),
        .state_o(ast_o), .fire_o(afire_o), .err_o(aerr_o)
    );

    // Count firing pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && fire_o)  dfires++;
        if (rst_n && afire_o) afires++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        din = 3'b000; ain = 2'b00; rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        dfires = 0; afires = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int qm, fb;
        do_reset();
        // R1: reset state of both instances
        chk("R1 state", st_o, 0); chk("R1 out", q_o, 0); chk("R1 err", err_o, 0);
        chk("R1 arc state", ast_o, 0); chk("R1 arc out", ao_o, 0);

        // Sweep the data pattern across clock-like cycles (R2 R3 R4 R5).
        qm = 0;
        for (int i = 0; i < 12; i++) begin
            int d;
            d = ((i * 7) >> 1) & 1;
            if (d != din[0]) begin
                fb = dfires;
                din = {1'b0, 1'b0, d[0]};
                wait_n(5);
                chk("R5 optional data change no error", err_o, 0);
                chk("R5 optional change does not fire", dfires, fb);
            end
            fb = dfires;
            din = {1'b0, 1'b1, d[0]};
            wait_n(5);
            qm = d;
            chk(d ? "R2 rise with data high" : "R4 rise with data low held level", q_o, qm);
            chk("R2 state follows value", st_o, qm);
            chk("R3 one firing per burst", dfires, fb + 1);
            fb = dfires;
            din = {1'b0, 1'b0, d[0]};
            wait_n(5);
            chk("R4 falling self-loop keeps out", q_o, qm);
            chk("R4 falling self-loop keeps state", st_o, qm);
            chk("R4 falling self-loop fires", dfires, fb + 1);
        end

        // R8: quiet inputs never fire.
        fb = dfires;
        wait_n(20);
        chk("R8 no firing without change", dfires, fb);
        chk("R8 no error when quiet", err_o, 0);

        // R7 and R11: data reverses within the pending burst.
        do_reset();
        din = 3'b001; wait_n(5);
        chk("R7 first data rise legal", err_o, 0);
        din = 3'b000; wait_n(5);
        chk("R7 reversal flagged", err_o, 1);
        din = 3'b011; wait_n(5);
        chk("R6 frozen out", q_o, 0);
        chk("R6 frozen state", st_o, 0);
        chk("R11 error sticky", err_o, 1);

        // R6: the spare input is listed nowhere.
        do_reset();
        din = 3'b100; wait_n(5);
        chk("R6 unlisted input flagged", err_o, 1);
        fb = dfires;
        din = 3'b111; wait_n(5);
        chk("R6 no firing after error", dfires, fb);
        chk("R6 out held after error", q_o, 0);
        din = 3'b000; wait_n(5);
        chk("R11 error stays after inputs return", err_o, 1);

        // R9: carried optional transition arriving early.
        do_reset();
        ain = 2'b10; wait_n(5);
        chk("R9 early y alone no move", ast_o, 0);
        chk("R5 early y no error", aerr_o, 0);
        ain = 2'b11; wait_n(5);
        chk("R9 x rise fires", ao_o, 1);
        chk("R9 x rise state", ast_o, 1);
        wait_n(10);
        chk("R9 carried y alone does not fire", ast_o, 1);
        chk("R9 no spurious fire", afires, 1);
        ain = 2'b10; wait_n(5);
        chk("R9 x fall completes with carried y", ast_o, 0);
        chk("R9 out toggled back", ao_o, 0);
        chk("R9 no error", aerr_o, 0);

        // R9: y arriving after entry.
        do_reset();
        ain = 2'b01; wait_n(5);
        chk("R9 late case enter", ast_o, 1);
        ain = 2'b11; wait_n(5);
        chk("R9 y alone waits for x fall", ast_o, 1);
        ain = 2'b10; wait_n(5);
        chk("R9 late case completes", ast_o, 0);
        chk("R3 two firings", afires, 2);

        // R7: carried transition reverses.
        do_reset();
        ain = 2'b10; wait_n(5);
        ain = 2'b11; wait_n(5);
        ain = 2'b01; wait_n(5);
        chk("R7 carried reversal flagged", aerr_o, 1);
        chk("R7 state held", ast_o, 1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule